// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers the interrupt requests of a small DSP core and turns them into one vectored request for the program sequencer. There are eleven sources plus the reset request. Six sources come from external request lines. Four of those lines can instead be driven by on-chip programmable flag outputs. The other sources are one-cycle pulses from the timer, the byte DMA engine, the two serial ports and the power-down logic. Software can also set or clear pending bits directly.

Each source has a fixed place in the priority order. A source that has a stored request, or an active level request, and that is enabled takes part in arbitration. The winner's vector is registered and presented with `req_o`. It stays unchanged until the sequencer acknowledges it, and only then is the next winner chosen.

External lines are active low and pass through a two-stage synchronizer. Some lines are always level-sensitive, one is always edge-sensitive, and three have a software-selected mode. Two of the slots can carry either the second serial port's own pulses or two external lines, chosen by a mode bit.

Top module: `irqv_ctrl`

## Requirements
- R1: While `rst_n` is low, `req_o` is 0 and `pend_o` is 0. After reset is released, the block first issues `req_o`=1 with vector 0. This reset request ignores `global_en_i` and `mask_i`, and it is cleared by its acknowledge.
- R2: Priority is fixed. Index 0 is the highest and index 10 the lowest. A source at index k gets vector 4*(k+1). The index order is: 0 power-down, 1 irq2 line, 2 level line 1, 3 level line 0, 4 serial port 0 transmit, 5 serial port 0 receive, 6 edge line, 7 byte DMA, 8 slot A, 9 slot B, 10 timer.
- R3: A maskable source (index 1 to 10) takes part in arbitration only when `global_en_i`=1 and its `mask_i` bit is 1. A stored request whose source is disabled stays visible in `pend_o`.
- R4: Power-down (index 0) is granted even when `global_en_i`=0 and every mask bit is 0.
- R5: A falling edge on an edge-sensitive line sets that source's pending bit. The bit stays set after the line returns high, and it is cleared when that source's vector is acknowledged.
- R6: Level line 0 and level line 1 are never latched. A low level that is removed before it is granted leaves no request behind.
- R7: `sens_edge_i` bit 0 (irq2 line), bit 1 (irq1 line) and bit 2 (irq0 line) choose the mode of each line: 1 means edge-sensitive, 0 means level-sensitive.
- R8: When `sp1_irq_mode_i`=0, slot A (index 8) takes `sp1_tx_i` and slot B (index 9) takes `sp1_rx_i`, and the irq1 and irq0 lines are ignored. When it is 1, slot A takes the irq1 line and slot B takes the irq0 line, and the two serial port pulses are ignored.
- R9: `flag_oe_i` and `flag_do_i` bit 0 belong to the irq2 line, bit 1 to level line 1, bit 2 to level line 0 and bit 3 to the edge line. When a line's `flag_oe_i` bit is 1, the flag value raises the interrupt and the external line is ignored.
- R10: A 1 on a `sw_set_i` bit sets the matching `pend_o` bit on the next cycle, and set wins over clear. A 1 on a `sw_clr_i` bit clears it.
- R11: Once `req_o` is 1, `vector_o` stays unchanged until `ack_i`=1 is sampled, even if a higher-priority request arrives. `req_o` drops in the cycle after the acknowledge, and arbitration resumes after that.
- R12: The timer, byte DMA, serial port and power-down pulses are each stored as pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq2_n_i | input | 1 | irq2 request line, active low, mode chosen by software |
| irql1_n_i | input | 1 | Level request line 1, active low |
| irql0_n_i | input | 1 | Level request line 0, active low |
| irqe_n_i | input | 1 | Edge request line, falling edge |
| irq1_n_i | input | 1 | irq1 line for slot A, active low |
| irq0_n_i | input | 1 | irq0 line for slot B, active low |
| flag_oe_i | input | 4 | Flag output enables of the shared lines |
| flag_do_i | input | 4 | Flag output values of the shared lines |
| pwrdn_i | input | 1 | Power-down request pulse |
| sp0_tx_i | input | 1 | Serial port 0 transmit pulse |
| sp0_rx_i | input | 1 | Serial port 0 receive pulse |
| bdma_i | input | 1 | Byte DMA pulse |
| sp1_tx_i | input | 1 | Serial port 1 transmit pulse |
| sp1_rx_i | input | 1 | Serial port 1 receive pulse |
| timer_i | input | 1 | Timer pulse |
| sp1_irq_mode_i | input | 1 | Assigns slots A and B to the external lines |
| sens_edge_i | input | 3 | Edge-mode select of the irq2, irq1 and irq0 lines |
| global_en_i | input | 1 | Global enable of the maskable sources |
| mask_i | input | 10 | Per-source enables, indices 10 down to 1 |
| sw_set_i | input | 11 | Software set of pending bits |
| sw_clr_i | input | 11 | Software clear of pending bits |
| pend_o | output | 11 | Stored pending bits by priority index |
| ack_i | input | 1 | Acknowledge of the presented vector |
| req_o | output | 1 | Vector request to the sequencer |
| vector_o | output | 8 | Vector address |

## Verification
The assertions check the handshake on every cycle. A presented vector must hold until it is acknowledged, and the request must drop right after the acknowledge. Every newly raised vector must belong to a source that was enabled when it won, the reset vector must come first after reset, and a software set must always land in the pending bits. Other behaviours need a stimulus history, so only the bench's scenarios can show them. These are the priority order among simultaneous requests, the difference between latched edges and unlatched levels, the slot reassignment, and the flag override of the external lines.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
   localparam int NSRC = 11;

   typedef enum logic [1:0] {
      SENS_LEVEL = 2'd0,
      SENS_EDGE  = 2'd1,
      SENS_PROG  = 2'd2
   } sens_kind_e;

   localparam int K_PWDN  = 0;
   localparam int K_IRQ2  = 1;
   localparam int K_IRQL1 = 2;
   localparam int K_IRQL0 = 3;
   localparam int K_SP0TX = 4;
   localparam int K_SP0RX = 5;
   localparam int K_IRQE  = 6;
   localparam int K_BDMA  = 7;
   localparam int K_SLOTA = 8;
   localparam int K_SLOTB = 9;
   localparam int K_TIMER = 10;
endpackage

// File: rtl/irqv_pin_cond.sv
module irqv_pin_cond
   import irqv_pkg::*;
#(
   parameter sens_kind_e KIND = SENS_LEVEL,
   parameter int         SYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n_i,
   input  logic prog_edge_i,
   output logic level_o,
   output logic fall_o
);
   if (SYNC < 2) begin : g_bad_sync
      $error("irqv_pin_cond: SYNC must be at least 2");
   end

   logic [SYNC-1:0] sync_q;
   logic            prev_q;
   logic            cur;
   logic            edge_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC-2:0], pin_n_i};
         prev_q <= sync_q[SYNC-1];
      end
   end

   assign cur = sync_q[SYNC-1];

   if (KIND == SENS_PROG) begin : g_prog
      assign edge_mode = prog_edge_i;
   end else begin : g_fixed
      logic unused_prog;
      assign unused_prog = prog_edge_i;
      assign edge_mode   = (KIND == SENS_EDGE);
   end

   assign level_o = ~edge_mode & ~cur;
   assign fall_o  = edge_mode & prev_q & ~cur;
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio #(
   parameter int N  = 12,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  req_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IW'(i);
      end
   end
   assign any_o = |req_i;
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
   import irqv_pkg::*;
#(
   parameter int VEC_W    = 8,
   parameter int VEC_STEP = 4,
   parameter int SYNC     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq2_n_i,
   input  logic             irql1_n_i,
   input  logic             irql0_n_i,
   input  logic             irqe_n_i,
   input  logic             irq1_n_i,
   input  logic             irq0_n_i,
   input  logic [3:0]       flag_oe_i,
   input  logic [3:0]       flag_do_i,
   input  logic             pwrdn_i,
   input  logic             sp0_tx_i,
   input  logic             sp0_rx_i,
   input  logic             bdma_i,
   input  logic             sp1_tx_i,
   input  logic             sp1_rx_i,
   input  logic             timer_i,
   input  logic             sp1_irq_mode_i,
   input  logic [2:0]       sens_edge_i,
   input  logic             global_en_i,
   input  logic [NSRC-1:1]  mask_i,
   input  logic [NSRC-1:0]  sw_set_i,
   input  logic [NSRC-1:0]  sw_clr_i,
   output logic [NSRC-1:0]  pend_o,
   input  logic             ack_i,
   output logic             req_o,
   output logic [VEC_W-1:0] vector_o
);
   localparam int NCAND = NSRC + 1;
   localparam int IW    = $clog2(NCAND);
   localparam int NPIN  = 6;
   localparam logic [VEC_W-1:0] STEP_V = VEC_W'(VEC_STEP);

   if (VEC_STEP < 1 || NSRC * VEC_STEP >= 2 ** VEC_W) begin : g_bad_vec
      $error("irqv_ctrl: VEC_W too narrow for NSRC*VEC_STEP");
   end

   // shared lines: flag output overrides the external pin
   logic [3:0]      shared_n;
   logic [NPIN-1:0] pin_n;
   logic [NPIN-1:0] prog_sel;
   logic [NPIN-1:0] lvl;
   logic [NPIN-1:0] fall;

   assign shared_n = (flag_oe_i & flag_do_i) |
                     (~flag_oe_i & {irqe_n_i, irql0_n_i, irql1_n_i, irq2_n_i});
   assign pin_n    = {irq0_n_i, irq1_n_i, shared_n};
   assign prog_sel = {sens_edge_i[2], sens_edge_i[1], 3'b000, sens_edge_i[0]};

   for (genvar g = 0; g < NPIN; g++) begin : g_pin
      localparam sens_kind_e KND = (g == 3) ? SENS_EDGE :
                                   ((g == 1 || g == 2) ? SENS_LEVEL : SENS_PROG);
      irqv_pin_cond #(.KIND(KND), .SYNC(SYNC)) u_cond (
         .clk        (clk),
         .rst_n      (rst_n),
         .pin_n_i    (pin_n[g]),
         .prog_edge_i(prog_sel[g]),
         .level_o    (lvl[g]),
         .fall_o     (fall[g])
      );
   end

   // per-source events
   logic [NSRC-1:0] set_ev;
   logic [NSRC-1:0] lvl_req;

   always_comb begin
      set_ev          = '0;
      lvl_req         = '0;
      set_ev[K_PWDN]  = pwrdn_i;
      set_ev[K_IRQ2]  = fall[0];
      lvl_req[K_IRQ2] = lvl[0];
      lvl_req[K_IRQL1] = lvl[1];
      lvl_req[K_IRQL0] = lvl[2];
      set_ev[K_SP0TX] = sp0_tx_i;
      set_ev[K_SP0RX] = sp0_rx_i;
      set_ev[K_IRQE]  = fall[3];
      set_ev[K_BDMA]  = bdma_i;
      set_ev[K_SLOTA] = sp1_irq_mode_i ? fall[4] : sp1_tx_i;
      set_ev[K_SLOTB] = sp1_irq_mode_i ? fall[5] : sp1_rx_i;
      lvl_req[K_SLOTA] = sp1_irq_mode_i & lvl[4];
      lvl_req[K_SLOTB] = sp1_irq_mode_i & lvl[5];
      set_ev[K_TIMER] = timer_i;
   end

   // pending store and grant register
   logic [NSRC-1:0]  pend_q;
   logic             rst_pend_q;
   logic             req_q;
   logic [IW-1:0]    gnt_q;
   logic             ack_fire;
   logic [NSRC-1:0]  clr_ack;
   logic [NSRC-1:0]  enable;
   logic [NCAND-1:0] cand;
   logic             any;
   logic [IW-1:0]    win;

   assign ack_fire = req_q & ack_i;
   assign enable   = {({(NSRC-1){global_en_i}} & mask_i), 1'b1};
   assign cand     = {(pend_q | lvl_req) & enable, rst_pend_q};

   always_comb begin
      clr_ack = '0;
      for (int k = 0; k < NSRC; k++) begin
         clr_ack[k] = ack_fire && (gnt_q == IW'(k + 1));
      end
   end

   irqv_prio #(.N(NCAND), .IW(IW)) u_prio (
      .req_i(cand),
      .any_o(any),
      .idx_o(win)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q     <= '0;
         rst_pend_q <= 1'b1;
         req_q      <= 1'b0;
         gnt_q      <= '0;
      end else begin
         pend_q <= (pend_q & ~clr_ack & ~sw_clr_i) | set_ev | sw_set_i;
         if (ack_fire && gnt_q == '0) rst_pend_q <= 1'b0;
         if (!req_q && any) begin
            req_q <= 1'b1;
            gnt_q <= win;
         end else if (ack_fire) begin
            req_q <= 1'b0;
         end
      end
   end

   assign pend_o   = pend_q;
   assign req_o    = req_q;
   assign vector_o = VEC_W'(gnt_q) * STEP_V;
endmodule

// File: rtl/irqv_ctrl_chk.sv
module irqv_ctrl_chk
   import irqv_pkg::*;
#(
   parameter int VEC_W    = 8,
   parameter int VEC_STEP = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             global_en_i,
   input logic [NSRC-1:1]  mask_i,
   input logic [NSRC-1:0]  sw_set_i,
   input logic [NSRC-1:0]  pend_o,
   input logic             ack_i,
   input logic             req_o,
   input logic [VEC_W-1:0] vector_o
);
   localparam int NCAND = NSRC + 1;
   localparam int IW    = $clog2(NCAND);

   logic             first_q;
   logic [NCAND-1:0] en_q;
   logic [IW-1:0]    gidx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= 1'b1;
         en_q    <= '1;
      end else begin
         first_q <= 1'b0;
         en_q    <= {({(NSRC-1){global_en_i}} & mask_i), 2'b11};
      end
   end

   assign gidx = IW'(vector_o / VEC_STEP);

   assert_reset_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
      first_q |=> (req_o && vector_o == '0));

   assert_vec_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !ack_i) |=> (req_o && $stable(vector_o)));

   assert_drop_after_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && ack_i) |=> !req_o);

   assert_grant_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_o) |-> en_q[gidx]);

   assert_sw_set_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|sw_set_i) |=> ((pend_o & $past(sw_set_i)) == $past(sw_set_i)));
endmodule

bind irqv_ctrl irqv_ctrl_chk #(.VEC_W(VEC_W), .VEC_STEP(VEC_STEP)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .global_en_i(global_en_i),
   .mask_i     (mask_i),
   .sw_set_i   (sw_set_i),
   .pend_o     (pend_o),
   .ack_i      (ack_i),
   .req_o      (req_o),
   .vector_o   (vector_o)
);

// File: tb/irqv_ctrl_bench.sv
module irqv_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq2_n = 1'b1, irql1_n = 1'b1, irql0_n = 1'b1, irqe_n = 1'b1;
   logic        irq1_n = 1'b1, irq0_n = 1'b1;
   logic [3:0]  flag_oe = '0, flag_do = '1;
   logic        pwrdn = 0, sp0_tx = 0, sp0_rx = 0, bdma = 0, sp1_tx = 0, sp1_rx = 0, timer = 0;
   logic        sp1_mode = 0;
   logic [2:0]  sens = '0;
   logic        gen = 0;
   logic [10:1] mask = '1;
   logic [10:0] sw_set = '0, sw_clr = '0;
   logic [10:0] pend;
   logic        ack = 0;
   logic        req;
   logic [7:0]  vec;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   irqv_ctrl u_irqv_ctrl (
      .clk(clk), .rst_n(rst_n),
      .irq2_n_i(irq2_n), .irql1_n_i(irql1_n), .irql0_n_i(irql0_n), .irqe_n_i(irqe_n),
      .irq1_n_i(irq1_n), .irq0_n_i(irq0_n),
      .flag_oe_i(flag_oe), .flag_do_i(flag_do),
      .pwrdn_i(pwrdn), .sp0_tx_i(sp0_tx), .sp0_rx_i(sp0_rx), .bdma_i(bdma),
      .sp1_tx_i(sp1_tx), .sp1_rx_i(sp1_rx), .timer_i(timer),
      .sp1_irq_mode_i(sp1_mode), .sens_edge_i(sens), .global_en_i(gen), .mask_i(mask),
      .sw_set_i(sw_set), .sw_clr_i(sw_clr), .pend_o(pend),
      .ack_i(ack), .req_o(req), .vector_o(vec)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wait_req(input int exp_vec, input string tag);
      for (int i = 0; i < 12 && !req; i++) tick(1);
      check(req === 1'b1, {tag, " request"}, int'(req), 1);
      check(vec === 8'(exp_vec), {tag, " vector"}, int'(vec), exp_vec);
   endtask

   task automatic do_ack();
      ack = 1'b1;
      tick(1);
      ack = 1'b0;
   endtask

   task automatic wait_grant(input int exp_vec, input string tag);
      wait_req(exp_vec, tag);
      do_ack();
   endtask

   task automatic expect_idle(input string tag);
      tick(8);
      check(req === 1'b0, {tag, " idle"}, int'(req), 0);
   endtask

   task automatic t_reset();
      tick(3);
      check(req === 1'b0, "R1 req in reset", int'(req), 0);
      check(pend === '0, "R1 pend in reset", int'(pend), 0);
      rst_n = 1'b1;
      wait_grant(0, "R1 reset vector unmaskable");
      expect_idle("R1 after reset ack");
   endtask

   task automatic t_priority();
      gen = 0;
      timer = 1; bdma = 1; sp0_rx = 1;
      tick(1);
      timer = 0; bdma = 0; sp0_rx = 0;
      tick(2);
      check(pend === 11'b10010100000, "R12 pulses stored", int'(pend), 11'b10010100000);
      gen = 1;
      wait_grant(24, "R2 first sp0 rx");
      wait_grant(32, "R2 second bdma");
      wait_grant(44, "R2 third timer");
      check(pend === '0, "R5 pend cleared by acks", int'(pend), 0);
      expect_idle("R2");
   endtask

   task automatic t_mask();
      mask[7] = 1'b0;
      bdma = 1; tick(1); bdma = 0;
      expect_idle("R3 masked bdma");
      check(pend[7] === 1'b1, "R3 masked stays pending", int'(pend[7]), 1);
      mask[7] = 1'b1;
      wait_grant(32, "R3 unmasked bdma");
   endtask

   task automatic t_pwrdn();
      gen = 0; mask = '0;
      pwrdn = 1; tick(1); pwrdn = 0;
      wait_grant(4, "R4 power-down unmaskable");
      expect_idle("R4");
      gen = 1; mask = '1;
   endtask

   task automatic t_edge();
      gen = 0;
      irqe_n = 0; tick(3); irqe_n = 1;
      tick(6);
      check(pend[6] === 1'b1, "R5 edge latched", int'(pend[6]), 1);
      gen = 1;
      wait_grant(28, "R5 edge grant");
      check(pend[6] === 1'b0, "R5 cleared by ack", int'(pend[6]), 0);
      expect_idle("R5");
   endtask

   task automatic t_level();
      gen = 0;
      irql0_n = 0; tick(4); irql0_n = 1;
      tick(4);
      gen = 1;
      expect_idle("R6 level not latched");
      irql0_n = 0;
      wait_req(16, "R6 level grant");
      irql0_n = 1;
      tick(4);
      check(req === 1'b1 && vec === 8'd16, "R11 held after level drop", int'(vec), 16);
      do_ack();
      expect_idle("R6 after release");
   endtask

   task automatic t_prog();
      gen = 0; sens[0] = 1'b0;
      irq2_n = 0; tick(3); irq2_n = 1;
      tick(4);
      gen = 1;
      expect_idle("R7 irq2 level mode");
      gen = 0; sens[0] = 1'b1;
      irq2_n = 0; tick(3); irq2_n = 1;
      tick(4);
      gen = 1;
      wait_grant(8, "R7 irq2 edge mode");
      expect_idle("R7");
      sens[0] = 1'b0;
   endtask

   task automatic t_slots();
      sp1_mode = 0; sens[1] = 1'b1; sens[2] = 1'b1;
      irq1_n = 0; tick(3); irq1_n = 1;
      expect_idle("R8 irq1 ignored in port mode");
      check(pend[8] === 1'b0, "R8 slot A not set by line", int'(pend[8]), 0);
      sp1_tx = 1; tick(1); sp1_tx = 0;
      wait_grant(36, "R8 slot A port pulse");
      sp1_mode = 1;
      sp1_rx = 1; tick(1); sp1_rx = 0;
      expect_idle("R8 port pulse ignored in line mode");
      check(pend[9] === 1'b0, "R8 slot B not set by pulse", int'(pend[9]), 0);
      irq0_n = 0; tick(3); irq0_n = 1;
      wait_grant(40, "R8 slot B line");
      expect_idle("R8");
      sp1_mode = 0; sens = '0;
   endtask

   task automatic t_flags();
      flag_oe[3] = 1'b1; flag_do[3] = 1'b1;
      irqe_n = 0; tick(3); irqe_n = 1;
      expect_idle("R9 external edge line ignored");
      flag_do[3] = 1'b0; tick(3); flag_do[3] = 1'b1;
      wait_grant(28, "R9 flag raises edge source");
      flag_oe[1] = 1'b1; flag_do[1] = 1'b0;
      wait_req(12, "R9 flag raises level source");
      flag_do[1] = 1'b1;
      tick(4);
      do_ack();
      expect_idle("R9");
      flag_oe = '0;
   endtask

   task automatic t_sw();
      gen = 0;
      sw_set = 11'b10000000100; tick(1); sw_set = '0;
      tick(1);
      check(pend === 11'b10000000100, "R10 sw set", int'(pend), 11'b10000000100);
      sw_clr = 11'b10000000000; tick(1); sw_clr = '0;
      tick(1);
      check(pend === 11'b00000000100, "R10 sw clear", int'(pend), 11'b00000000100);
      gen = 1;
      wait_grant(12, "R10 sw request");
      expect_idle("R10");
   endtask

   task automatic t_hold();
      timer = 1; tick(1); timer = 0;
      wait_req(44, "R11 timer");
      pwrdn = 1; tick(1); pwrdn = 0;
      tick(4);
      check(req === 1'b1 && vec === 8'd44, "R11 held against higher", int'(vec), 44);
      do_ack();
      check(req === 1'b0, "R11 drop after ack", int'(req), 0);
      wait_grant(4, "R11 next winner");
      expect_idle("R11");
   endtask

   initial begin
      tick(1);
      t_reset();
      gen = 1;
      t_priority();
      t_mask();
      t_pwrdn();
      t_edge();
      t_level();
      t_prog();
      t_slots();
      t_flags();
      t_sw();
      t_hold();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule